// File: doc/BRIEF.md
# Primary Command Stream Decoder

This block walks a command stream held in memory and turns it into register writes. Software writes a start address and an end address into two host-side registers. Writing the end address launches fetching, unless bit 0 of the written value asks for the launch to be held back. The fetcher reads 32-bit words one at a time over a valid/ready read port. It collects them into five-word blocks. Each block is one header word carrying four packed 8-bit register indices, followed by four data words.

A full block goes to the issue stage. The issue stage expands each index into a 16-bit register byte address and sends the four writes, strictly in slot order, over a valid/ready write port. Indices name registers in one of two 512-byte banks. Writing through the alias window that sits 0x100 above each register base raises a one-cycle execute pulse for the downstream engine.

A small status unit keeps a software-trap flag, a maskable interrupt and an end-of-stream flag. It also reports idleness for the whole unit.

Top module: `cmdq_decoder`

## Requirements
- R1: A block is five consecutive words: a header, then data words 0 to 3. Data word k is written to the register named by header byte k, which is bits 8k+7:8k. The four writes leave in the order k = 0, 1, 2, 3, and blocks leave in stream order.
- R2: Index expansion depends on bit 7 of the index. If bit 7 is 0, the address is 0x1C00 + idx[6:0]*4. If bit 7 is 1, the address is 0x2C00 + idx[6:0]*4. Every issued address is therefore word aligned and lies in 0x1C00..0x1DFF or 0x2C00..0x2DFF.
- R3: A write whose address has bit 8 set (index bit 6 set) is an execute alias. It makes `exec_pulse` high for exactly the one cycle that follows its write handshake. No other cycle has `exec_pulse` high.
- R4: A host write to 0x1E58 loads the fetch pointer with the written value, low two bits cleared. The same write loads `stream_type` with the written bits 1:0.
- R5: A host write to 0x1E5C stores the end address, low two bits cleared. If written bit 0 is 0, fetching starts and status bit 17 clears. If written bit 0 is 1, nothing is fetched and `rd_valid` stays low.
- R6: Fetching stops when the pointer equals the end address and no full block is waiting. At that point status bit 17 sets and `cur_ptr` holds the end address. Words of an incomplete final block are dropped, and no write is issued for them.
- R7: `status` has bit 0 = trap pending, bit 16 = `draw_busy`, bit 17 = stream stopped, and all other bits 0. `idle` is high exactly when bit 17 is the only one of those three that is set.
- R8: A stream write to 0x2C48, or to its alias 0x2D48, sets status bit 0. A host write of 1 in bit 0 to 0x1E18 clears it. If both happen in the same cycle, the set takes effect.
- R9: Bit 0 of the host register at 0x1E1C is the interrupt enable. `irq` equals status bit 0 AND that enable.
- R10: A stream write to the pad register 0x1C54 is issued like any other write. It raises no `exec_pulse` and leaves `status` unchanged.
- R11: While `wr_ready` is low, `wr_valid` stays high with `wr_addr` and `wr_data` unchanged. Backpressure on either port loses, repeats or reorders no write.
- R12: A synchronous reset clears the pointer, the end address, the interrupt enable and the trap flag. After reset, `status` reads 0x00020000 (with `draw_busy` low), and `wr_valid`, `rd_valid`, `exec_pulse` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register byte address |
| host_wdata | input | 32 | Host register write value |
| draw_busy | input | 1 | Drawing engine busy, reflected in status bit 16 |
| rd_valid | output | 1 | Stream word fetch request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_ready | input | 1 | Fetch accepted; `rd_data` is valid in the same cycle |
| rd_data | input | 32 | Fetched stream word |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register write value |
| wr_ready | input | 1 | Register write accepted |
| exec_pulse | output | 1 | One-cycle execute strobe for the engine |
| irq | output | 1 | Trap interrupt |
| idle | output | 1 | Stream stopped, no trap pending, engine not busy |
| status | output | 32 | Status word |
| stream_type | output | 2 | Stream type from the start register |
| cur_ptr | output | ADDR_W | Current fetch pointer |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- the write port holds a stalled request unchanged;
- every issued address lies in one of the two banks;
- an execute pulse always follows a write handshake;
- the trap flag only rises after a trap write;
- a stopped pointer does not move;
- fetching only stops when no full block is waiting.

Other behaviours need the bench's scenarios to show them:
- the exact address expansion and data pairing for chosen indices;
- discarding of a partial tail block;
- the held-back launch;
- the interrupt gating and clearing;
- the pad register's lack of side effects;
- correct write order under irregular backpressure on both ports.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
    localparam int SLOTS     = 4;
    localparam int BLK_WORDS = SLOTS + 1;

    localparam logic [15:0] REG_START = 16'h1E58;
    localparam logic [15:0] REG_END   = 16'h1E5C;
    localparam logic [15:0] REG_ICLR  = 16'h1E18;
    localparam logic [15:0] REG_IEN   = 16'h1E1C;
    localparam logic [15:0] REG_TRAP  = 16'h2C48;
    localparam logic [15:0] BANK0     = 16'h1C00;
    localparam logic [15:0] BANK1     = 16'h2C00;
    localparam logic [15:0] EXEC_OFS  = 16'h0100;

    localparam int ST_TRAP = 0;
    localparam int ST_BUSY = 16;
    localparam int ST_DONE = 17;

    typedef logic [31:0] word_t;

    // Expand a packed 8-bit index into a register byte address.
    function automatic logic [15:0] idx_to_addr(input logic [7:0] idx);
        return (idx[7] ? BANK1 : BANK0) + {7'd0, idx[6:0], 2'b00};
    endfunction

    // Index bit 6 selects the upper half of a bank: the execute alias.
    function automatic logic idx_is_exec(input logic [7:0] idx);
        return idx[6];
    endfunction
endpackage

// File: rtl/cmdq_fetch.sv
`timescale 1ns/1ps
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             host_we,
    input  logic [15:0]                      host_addr,
    input  word_t                            host_wdata,
    output logic                             rd_valid,
    input  logic                             rd_ready,
    output logic [ADDR_W-1:0]                rd_addr,
    input  word_t                            rd_data,
    input  logic                             blk_take,
    output logic                             blk_full,
    output logic [BLK_WORDS-1:0][31:0]       blk_words,
    output logic                             run,
    output logic [1:0]                       stream_type
);
    localparam int                CNT_W     = $clog2(BLK_WORDS);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(3);

    typedef struct packed {
        logic [ADDR_W-1:0]          ptr;
        logic [ADDR_W-1:0]          stop;
        logic [1:0]                 kind;
        logic                       run;
        logic                       full;
        logic [CNT_W-1:0]           cnt;
        logic [BLK_WORDS-1:0][31:0] words;
    } fetch_st_t;

    fetch_st_t st_d, st_q;
    logic      at_end;
    logic      wr_start;
    logic      wr_end;

    always_comb begin
        at_end   = (st_q.ptr == st_q.stop);
        rd_valid = st_q.run && !st_q.full && !at_end;
        wr_start = host_we && (host_addr == REG_START);
        wr_end   = host_we && (host_addr == REG_END);
        st_d     = st_q;

        if (rd_valid && rd_ready) begin
            st_d.words[st_q.cnt] = rd_data;
            st_d.ptr             = st_q.ptr + WORD_STEP;
            if (st_q.cnt == CNT_W'(BLK_WORDS - 1)) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (blk_take) begin
            st_d.full = 1'b0;
        end
        // Stream end: a partially collected block is thrown away.
        if (st_q.run && !st_q.full && at_end) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end
        if (wr_start) begin
            st_d.ptr  = host_wdata[ADDR_W-1:0] & ALIGN_MSK;
            st_d.kind = host_wdata[1:0];
            st_d.cnt  = '0;
        end
        if (wr_end) begin
            st_d.stop = host_wdata[ADDR_W-1:0] & ALIGN_MSK;
            if (!host_wdata[0]) begin
                st_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr     = st_q.ptr;
    assign blk_full    = st_q.full;
    assign blk_words   = st_q.words;
    assign run         = st_q.run;
    assign stream_type = st_q.kind;

    AST_PTR_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!st_q.run && !wr_start) |=> $stable(st_q.ptr)) else $error("pointer moved while stopped"); // R6
    AST_STOP_ONLY_DRAINED: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.run) |-> $past(!st_q.full)) else $error("stream stopped with block pending"); // R6
endmodule

// File: rtl/cmdq_issue.sv
`timescale 1ns/1ps
module cmdq_issue
    import cmdq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       blk_full,
    input  logic [BLK_WORDS-1:0][31:0] blk_words,
    output logic                       blk_take,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [15:0]                wr_addr,
    output word_t                      wr_data,
    output logic                       exec_pulse,
    output logic                       trap_hit
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int SEL_W  = $clog2(BLK_WORDS);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              exec;
    } issue_st_t;

    issue_st_t        st_d, st_q;
    logic [7:0]       cur_idx;
    logic [SEL_W-1:0] data_sel;
    logic             hs;

    always_comb begin
        cur_idx  = blk_words[0][8*st_q.slot +: 8];
        data_sel = SEL_W'(st_q.slot) + SEL_W'(1);
        wr_valid = blk_full;
        wr_addr  = idx_to_addr(cur_idx);
        wr_data  = blk_words[data_sel];
        hs       = wr_valid && wr_ready;
        blk_take = hs && (st_q.slot == SLOT_W'(SLOTS - 1));
        trap_hit = hs && ((wr_addr & ~EXEC_OFS) == REG_TRAP);

        st_d      = st_q;
        st_d.exec = hs && idx_is_exec(cur_idx);
        if (blk_take) begin
            st_d.slot = '0;
        end else if (hs) begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exec_pulse = st_q.exec;

    AST_WR_HELD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)))
        else $error("stalled write changed"); // R11
    AST_WR_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00 &&
                      ((wr_addr >= BANK0 && wr_addr <= 16'h1DFF) ||
                       (wr_addr >= BANK1 && wr_addr <= 16'h2DFF))))
        else $error("write outside register banks"); // R2
    AST_EXEC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> $past(hs)) else $error("execute pulse without write"); // R3
endmodule

// File: rtl/cmdq_status.sv
`timescale 1ns/1ps
module cmdq_status
    import cmdq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [15:0] host_addr,
    input  logic        host_bit0,
    input  logic        trap_hit,
    input  logic        draw_busy,
    input  logic        stream_run,
    output word_t       status,
    output logic        idle,
    output logic        irq
);
    localparam word_t IDLE_MASK = word_t'((1 << ST_TRAP) | (1 << ST_BUSY) | (1 << ST_DONE));
    localparam word_t IDLE_WANT = word_t'(1 << ST_DONE);

    typedef struct packed {
        logic trap;
        logic ien;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_we && host_addr == REG_ICLR && host_bit0) begin
            st_d.trap = 1'b0;
        end
        if (trap_hit) begin
            st_d.trap = 1'b1;
        end
        if (host_we && host_addr == REG_IEN) begin
            st_d.ien = host_bit0;
        end

        status          = '0;
        status[ST_TRAP] = st_q.trap;
        status[ST_BUSY] = draw_busy;
        status[ST_DONE] = !stream_run;
        idle            = ((status & IDLE_MASK) == IDLE_WANT);
        irq             = st_q.trap && st_q.ien;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TRAP_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.trap) |-> $past(trap_hit)) else $error("trap set without trap write"); // R8
endmodule

// File: rtl/cmdq_decoder.sv
`timescale 1ns/1ps
module cmdq_decoder
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              draw_busy,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              wr_valid,
    output logic [15:0]       wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              exec_pulse,
    output logic              irq,
    output logic              idle,
    output logic [31:0]       status,
    output logic [1:0]        stream_type,
    output logic [ADDR_W-1:0] cur_ptr
);
    logic                       blk_full;
    logic                       blk_take;
    logic [BLK_WORDS-1:0][31:0] blk_words;
    logic                       stream_run;
    logic                       trap_hit;

    cmdq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .blk_take   (blk_take),
        .blk_full   (blk_full),
        .blk_words  (blk_words),
        .run        (stream_run),
        .stream_type(stream_type)
    );

    cmdq_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .blk_full  (blk_full),
        .blk_words (blk_words),
        .blk_take  (blk_take),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .exec_pulse(exec_pulse),
        .trap_hit  (trap_hit)
    );

    cmdq_status u_status (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_bit0 (host_wdata[0]),
        .trap_hit  (trap_hit),
        .draw_busy (draw_busy),
        .stream_run(stream_run),
        .status    (status),
        .idle      (idle),
        .irq       (irq)
    );

    assign cur_ptr = rd_addr;
endmodule

// File: tb/cmdq_decoder_test.sv
`timescale 1ns/1ps
module cmdq_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        draw_busy = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_ready = 1'b1;
    logic [31:0] rd_data;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        exec_pulse, irq, idle;
    logic [31:0] status;
    logic [1:0]  stream_type;
    logic [31:0] cur_ptr;

    logic [31:0] mem [0:127];
    assign rd_data = mem[rd_addr[8:2]];

    always #2.5 clk = ~clk;

    cmdq_decoder #(.ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .draw_busy(draw_busy), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .exec_pulse(exec_pulse), .irq(irq), .idle(idle),
        .status(status), .stream_type(stream_type), .cur_ptr(cur_ptr)
    );

    int total = 0, bad = 0;
    int mon_total = 0, mon_bad = 0, exec_cnt = 0, log_n = 0;
    logic [15:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    logic        prev_hs = 1'b0, prev_exec = 1'b0, prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [31:0] prev_data = '0;

    // Write-port monitor: log writes, check execute pulses (R3) and stall holding (R11).
    always @(posedge clk) begin
        if (rst) begin
            prev_hs = 1'b0; prev_exec = 1'b0; prev_stall = 1'b0;
        end else begin
            if (exec_pulse) exec_cnt++;
            if (prev_hs || exec_pulse) begin
                mon_total++;
                if (exec_pulse !== prev_exec) begin
                    mon_bad++;
                    $display("FAIL R3 exec_pulse actual=%0b expected=%0b", exec_pulse, prev_exec);
                end
            end
            if (prev_stall) begin
                mon_total++;
                if (!(wr_valid && wr_addr == prev_addr && wr_data == prev_data)) begin
                    mon_bad++;
                    $display("FAIL R11 stalled write actual=%h/%h expected=%h/%h",
                             wr_addr, wr_data, prev_addr, prev_data);
                end
            end
            if (wr_valid && wr_ready && log_n < 64) begin
                log_addr[log_n] = wr_addr;
                log_data[log_n] = wr_data;
                log_n++;
            end
            prev_hs    = wr_valid && wr_ready;
            prev_exec  = prev_hs && wr_addr[8];
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_done(input bit bp);
        bit seen = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (bp) begin
                rd_ready = (c % 3) != 2;
                wr_ready = (c % 5) >= 2;
            end
            if (status[17]) begin
                seen = 1'b1;
                break;
            end
        end
        rd_ready = 1'b1;
        wr_ready = 1'b1;
        check(seen, "R6 stream end reached", {31'd0, seen}, 32'd1);
    endtask

    // Expansion vectors: index byte and expected register address (R1, R2).
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 16'h1C00}, {8'h15, 16'h1C54}, {8'h3F, 16'h1CFC}, {8'h80, 16'h2C00},
        {8'h92, 16'h2C48}, {8'hBF, 16'h2CFC}, {8'h40, 16'h1D00}, {8'hC1, 16'h2D04}
    };

    localparam logic [15:0] A_START = 16'h1E58, A_END = 16'h1E5C;
    localparam logic [15:0] A_ICLR = 16'h1E18, A_IEN = 16'h1E1C;

    initial begin
        int base, ex0;
        logic [31:0] st_before;
        for (int i = 0; i < 128; i++) mem[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(status == 32'h0002_0000, "R12 status after reset", status, 32'h0002_0000);
        check(!wr_valid && !rd_valid && !irq && !exec_pulse, "R12 outputs low after reset",
              {28'd0, wr_valid, rd_valid, irq, exec_pulse}, 32'd0);
        check(cur_ptr == 0, "R12 pointer after reset", cur_ptr, 0);
        check(idle, "R7 idle after reset", {31'd0, idle}, 32'd1);

        // Table walk: two blocks built from the vectors (R1, R2, R3, R4, R8).
        for (int i = 0; i < 8; i++) begin
            mem[(i / 4) * 5][8 * (i % 4) +: 8] = VEC[i][23:16];
            mem[(i / 4) * 5 + 1 + (i % 4)] = 32'hD000_0000 + i;
        end
        base = log_n; ex0 = exec_cnt;
        host_wr(A_START, 32'h0000_0002);
        check(stream_type == 2'd2, "R4 stream type", {30'd0, stream_type}, 32'd2);
        host_wr(A_END, 32'h0000_0028);
        wait_done(1'b0);
        check(log_n - base == 8, "R1 write count", log_n - base, 8);
        for (int i = 0; i < 8; i++) begin
            check(log_addr[base + i] == VEC[i][15:0], "R2 expanded address", {16'd0, log_addr[base + i]}, {16'd0, VEC[i][15:0]});
            check(log_data[base + i] == 32'hD000_0000 + i, "R1 data pairing", log_data[base + i], 32'hD000_0000 + i);
        end
        check(exec_cnt - ex0 == 2, "R3 execute pulses", exec_cnt - ex0, 2);
        check(cur_ptr == 32'h28, "R6 pointer holds at end", cur_ptr, 32'h28);
        check(status[0], "R8 trap set by stream write", status, 32'h0002_0001);
        check(!irq, "R9 irq masked", {31'd0, irq}, 0);
        check(!idle, "R7 not idle with trap", {31'd0, idle}, 0);

        // Interrupt enable and clear (R8, R9).
        host_wr(A_IEN, 32'h1);
        check(irq, "R9 irq enabled", {31'd0, irq}, 1);
        host_wr(A_ICLR, 32'h0);
        check(status[0], "R8 clear with bit0 low ignored", status, 32'h0002_0001);
        host_wr(A_ICLR, 32'h1);
        check(status == 32'h0002_0000, "R8 trap cleared", status, 32'h0002_0000);
        check(!irq && idle, "R9 irq drops, R7 idle", {30'd0, irq, idle}, 32'd1);

        // Engine busy (R7).
        @(negedge clk); draw_busy = 1'b1;
        @(negedge clk);
        check(status == 32'h0003_0000 && !idle, "R7 busy bit", status, 32'h0003_0000);
        draw_busy = 1'b0;

        // Pad register (R10).
        mem[16] = 32'h1515_1515;
        for (int i = 0; i < 4; i++) mem[17 + i] = 32'hA000_0000 + i;
        base = log_n; ex0 = exec_cnt;
        st_before = 32'h0002_0000;
        host_wr(A_START, 32'h40);
        host_wr(A_END, 32'h54);
        wait_done(1'b0);
        check(log_n - base == 4, "R10 pad writes issued", log_n - base, 4);
        for (int i = 0; i < 4; i++)
            check(log_addr[base + i] == 16'h1C54, "R10 pad address", {16'd0, log_addr[base + i]}, 32'h1C54);
        check(exec_cnt == ex0, "R10 no execute on pad", exec_cnt - ex0, 0);
        check(status == st_before, "R10 status unchanged", status, st_before);

        // Held launch, then real launch (R5).
        mem[32] = 32'h8483_8281;
        for (int i = 0; i < 4; i++) mem[33 + i] = 32'hC000_0000 + i;
        base = log_n;
        host_wr(A_START, 32'h81);
        check(stream_type == 2'd1 && cur_ptr == 32'h80, "R4 start loads pointer", cur_ptr, 32'h80);
        host_wr(A_END, 32'h95);
        begin
            int fetches = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (rd_valid) fetches++;
            end
            check(fetches == 0, "R5 held launch fetches nothing", fetches, 0);
        end
        check(status[17] && cur_ptr == 32'h80 && log_n == base, "R5 held launch stays stopped", cur_ptr, 32'h80);
        host_wr(A_END, 32'h94);
        check(!status[17], "R5 launch clears end flag", status, 32'h0);
        wait_done(1'b0);
        check(log_n - base == 4 && log_addr[base] == 16'h2C04, "R5 launched stream writes",
              {16'd0, log_addr[base]}, 32'h2C04);

        // Backpressure on both ports (R11, R1).
        for (int i = 0; i < 8; i++) begin
            mem[64 + (i / 4) * 5][8 * (i % 4) +: 8] = 8'h10 + 8'(i);
            mem[64 + (i / 4) * 5 + 1 + (i % 4)] = 32'hB000_0000 + i;
        end
        base = log_n;
        host_wr(A_START, 32'h100);
        host_wr(A_END, 32'h128);
        wait_done(1'b1);
        check(log_n - base == 8, "R11 no write lost", log_n - base, 8);
        for (int i = 0; i < 8; i++) begin
            check(log_addr[base + i] == 16'h1C40 + 16'(4 * i), "R11 order under stall",
                  {16'd0, log_addr[base + i]}, 32'h1C40 + 4 * i);
            check(log_data[base + i] == 32'hB000_0000 + i, "R11 data under stall",
                  log_data[base + i], 32'hB000_0000 + i);
        end

        // Partial tail block is dropped (R6).
        mem[80] = 32'h0403_0201;
        for (int i = 0; i < 4; i++) mem[81 + i] = 32'hE000_0000 + i;
        mem[85] = 32'h4040_4040;
        mem[86] = 32'hEEEE_EEEE;
        base = log_n; ex0 = exec_cnt;
        host_wr(A_START, 32'h140);
        host_wr(A_END, 32'h15C);
        wait_done(1'b0);
        repeat (5) @(negedge clk);
        check(log_n - base == 4, "R6 partial block discarded", log_n - base, 4);
        check(exec_cnt == ex0, "R6 no execute from partial block", exec_cnt - ex0, 0);
        check(cur_ptr == 32'h15C, "R6 pointer at end", cur_ptr, 32'h15C);

        // Reset in the middle of a stalled stream (R12).
        wr_ready = 1'b0;
        host_wr(A_START, 32'h0);
        host_wr(A_END, 32'h28);
        repeat (10) @(negedge clk);
        check(wr_valid, "R11 write waits for ready", {31'd0, wr_valid}, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!wr_valid && !rd_valid && status == 32'h0002_0000 && cur_ptr == 0 && !irq,
              "R12 reset mid-stream", status, 32'h0002_0000);
        rst = 1'b0;
        wr_ready = 1'b1;
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
        $finish;
    end
endmodule